// File: doc/BRIEF.md
# Unsigned Saturating Vector Narrowing Unit

The unit narrows the elements of a 128-bit source vector to half their width. Every element is read as an unsigned number. An element that fits in the narrow width passes through unchanged. An element that does not fit is clamped to the largest narrow value, which is all ones. The narrowed lanes are packed into a 64-bit result, and that result is merged into a 128-bit destination. The lower-half form clears the upper destination bits. The upper-half form keeps the lower bits of the previous destination, which the caller supplies on `dst_prev`.

A scalar mode narrows only the lowest element. It writes that one element into the lowest bits of the destination.

A sticky saturation flag records any clamp and holds until it is cleared. A reserved width code is reported as an undefined operation and changes nothing. The results appear one clock after a request is accepted.

Top module: `usat_narrow_unit`

## Requirements
- R1: `width_code` selects the narrowing:
  - 2'b00: 16-bit elements to 8 bits.
  - 2'b01: 32-bit elements to 16 bits.
  - 2'b10: 64-bit elements to 32 bits.
  - Placement: with narrow width w, source lane e occupies bits starting at e*2w and its narrow value goes to result bits starting at e*w.
- R2: `width_code` 2'b11 is reserved. It raises `undef_op` together with `out_valid`, and leaves `dst_out` and `sat_sticky` unchanged.
- R3: An element greater than 2^w-1 produces all ones. Any other element passes through unchanged; this includes exactly 2^w-1.
- R4: In vector mode (`scalar_mode`=0), every one of the 64/w lanes is narrowed (8, 4 or 2 lanes).
- R5: Vector mode with `upper_sel`=0:
  - The packed result goes to `dst_out[63:0]`.
  - `dst_out[127:64]` is cleared to zero.
- R6: Vector mode with `upper_sel`=1:
  - The packed result goes to `dst_out[127:64]`.
  - `dst_out[63:0]` takes the value of `dst_prev[63:0]`.
- R7: Scalar mode (`scalar_mode`=1):
  - Only source bits [2w-1:0] are narrowed.
  - The narrow value is written to `dst_out[w-1:0]`, and all higher destination bits are zero.
  - `upper_sel` has no effect.
  - Higher source lanes do not affect `sat_sticky`.
- R8: `sat_sticky` is set when any processed lane clamps, and it stays set until `sat_clear` or reset. A clamp in the same cycle as `sat_clear` leaves the flag set.
- R9: Outputs register one cycle after `in_valid`. `out_valid` is high for exactly that cycle, and `dst_out` holds its value while no request is accepted.
- R10: After reset, `out_valid`, `undef_op`, `sat_sticky` and `dst_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 128 | Source vector of double-width elements |
| width_code | input | 2 | Narrowing width selector |
| scalar_mode | input | 1 | 1: narrow the lowest element only |
| upper_sel | input | 1 | 1: write the result to the upper destination half |
| dst_prev | input | 128 | Previous destination value |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result valid, one cycle after the request |
| dst_out | output | 128 | Merged destination |
| sat_sticky | output | 1 | Cumulative saturation flag |
| undef_op | output | 1 | Reserved width code seen |

## Verification
The assertions check on every cycle the properties that do not depend on lane values:
- the one-cycle valid latency;
- the hold of the destination after a reserved code;
- the zero upper half for lower-half and scalar writes;
- the lower-half copy for upper-half writes;
- the flag staying set when no clear arrives;
- the all-ones output of every clamping lane.

Lane placement, the exact boundary at 2^w-1, and the separate behaviour of each width code can only be shown by the bench scenarios. The same holds for the scalar mode ignoring upper lanes and for the clear-versus-set ordering. The bench compares each of these against its own loop model of the narrowing.

// File: rtl/usat_narrow_pkg.sv
package usat_narrow_pkg;
  typedef enum logic [1:0] {
    WC_B8   = 2'b00,
    WC_H16  = 2'b01,
    WC_W32  = 2'b10,
    WC_RSVD = 2'b11
  } width_code_e;

  // Narrow element width in bits for a valid width code.
  function automatic int unsigned narrow_bits(input logic [1:0] code);
    return 32'd8 << code;
  endfunction

  // Number of vector lanes for a given result width and code.
  function automatic int unsigned lane_count(input int unsigned res_bits, input logic [1:0] code);
    return res_bits / narrow_bits(code);
  endfunction
endpackage

// File: rtl/usat_lane_clamp.sv
module usat_lane_clamp #(
  parameter int NW = 8
) (
  input  logic [2*NW-1:0] wide_in,
  output logic [NW-1:0]   narrow_out,
  output logic            clamped
);
  // Any set bit above the narrow width means the value exceeds 2^NW-1.
  assign clamped    = |wide_in[2*NW-1:NW];
  assign narrow_out = clamped ? {NW{1'b1}} : wide_in[NW-1:0];

  // R3: a clamping lane always yields the all-ones value.
  always_comb begin
    a_r3_clamp_all_ones: assert (!clamped || narrow_out == {NW{1'b1}});
  end
endmodule

// File: rtl/usat_half_merge.sv
module usat_half_merge #(
  parameter int HALF = 64
) (
  input  logic [HALF-1:0]   vec_res,
  input  logic [HALF-1:0]   scl_res,
  input  logic              scalar_mode,
  input  logic              upper_sel,
  input  logic [2*HALF-1:0] dst_prev,
  output logic [2*HALF-1:0] dst_next
);
  always_comb begin
    if (scalar_mode)
      dst_next = {{HALF{1'b0}}, scl_res};
    else if (upper_sel)
      dst_next = {vec_res, dst_prev[HALF-1:0]};
    else
      dst_next = {{HALF{1'b0}}, vec_res};
  end
endmodule

// File: rtl/usat_narrow_unit.sv
module usat_narrow_unit #(
  parameter int RES_BITS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [2*RES_BITS-1:0] src_vec,
  input  logic [1:0]            width_code,
  input  logic                  scalar_mode,
  input  logic                  upper_sel,
  input  logic [2*RES_BITS-1:0] dst_prev,
  input  logic                  sat_clear,
  output logic                  out_valid,
  output logic [2*RES_BITS-1:0] dst_out,
  output logic                  sat_sticky,
  output logic                  undef_op
);
  import usat_narrow_pkg::*;

  localparam int HALF   = RES_BITS;
  localparam int FULL   = 2 * RES_BITS;
  localparam int NCODES = 3;
  localparam int MAXL   = HALF / 8;

  logic [NCODES-1:0][HALF-1:0] vec_res;
  logic [NCODES-1:0][HALF-1:0] scl_res;
  logic [NCODES-1:0][MAXL-1:0] lane_sat;

  for (genvar s = 0; s < NCODES; s++) begin : g_width
    localparam int NW    = 8 << s;
    localparam int LANES = HALF / NW;
    for (genvar e = 0; e < LANES; e++) begin : g_lane
      usat_lane_clamp #(.NW(NW)) u_clamp (
        .wide_in    (src_vec[e*2*NW +: 2*NW]),
        .narrow_out (vec_res[s][e*NW +: NW]),
        .clamped    (lane_sat[s][e])
      );
    end
    if (LANES < MAXL) begin : g_pad
      assign lane_sat[s][MAXL-1:LANES] = '0;
    end
    assign scl_res[s] = {{(HALF-NW){1'b0}}, vec_res[s][NW-1:0]};
  end

  // Named internal events
  logic            code_ok;
  logic            accept;
  logic            reject;
  logic            sat_event;
  logic [HALF-1:0] sel_vec;
  logic [HALF-1:0] sel_scl;
  logic [MAXL-1:0] sel_sat;
  logic [FULL-1:0] dst_next;

  assign code_ok = (width_code != WC_RSVD);
  assign accept  = in_valid && code_ok;
  assign reject  = in_valid && !code_ok;

  always_comb begin
    case (width_code)
      WC_H16:  begin sel_vec = vec_res[1]; sel_scl = scl_res[1]; sel_sat = lane_sat[1]; end
      WC_W32:  begin sel_vec = vec_res[2]; sel_scl = scl_res[2]; sel_sat = lane_sat[2]; end
      default: begin sel_vec = vec_res[0]; sel_scl = scl_res[0]; sel_sat = lane_sat[0]; end
    endcase
  end

  // Scalar mode: only lane 0 can report a clamp.
  assign sat_event = accept &&
                     (scalar_mode ? sel_sat[0] : (|sel_sat));

  usat_half_merge #(.HALF(HALF)) u_merge (
    .vec_res     (sel_vec),
    .scl_res     (sel_scl),
    .scalar_mode (scalar_mode),
    .upper_sel   (upper_sel),
    .dst_prev    (dst_prev),
    .dst_next    (dst_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      undef_op   <= 1'b0;
      dst_out    <= '0;
      sat_sticky <= 1'b0;
    end else begin
      out_valid <= in_valid;
      undef_op  <= reject;
      if (accept)
        dst_out <= dst_next;
      sat_sticky <= (sat_clear ? 1'b0 : sat_sticky) | sat_event;
    end
  end

  // R9: one-cycle latency of the valid strobe.
  a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2: a reserved code leaves the destination untouched.
  a_r2_undef_holds_dst: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (undef_op && $stable(dst_out)));

  // R5 / R7: lower-half and scalar writes clear the upper half.
  a_r5_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (scalar_mode || !upper_sel)) |=> (dst_out[FULL-1:HALF] == '0));

  // R6: an upper-half write keeps the previous lower half.
  a_r6_lower_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !scalar_mode && upper_sel) |=> (dst_out[HALF-1:0] == $past(dst_prev[HALF-1:0])));

  // R8: without a clear the flag never falls; a clamp always sets it.
  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !sat_clear) |=> sat_sticky);
  a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sat_event |=> sat_sticky);
endmodule

// File: tb/usat_narrow_unit_tb_top.sv
module usat_narrow_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src_vec = '0;
  logic [1:0]   width_code = 2'b00;
  logic         scalar_mode = 1'b0;
  logic         upper_sel = 1'b0;
  logic [127:0] dst_prev = '0;
  logic         sat_clear = 1'b0;
  logic         out_valid;
  logic [127:0] dst_out;
  logic         sat_sticky;
  logic         undef_op;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [127:0] exp_dst = '0;
  logic         exp_sat = 1'b0;

  always #5 clk = ~clk;

  usat_narrow_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .width_code(width_code), .scalar_mode(scalar_mode), .upper_sel(upper_sel),
    .dst_prev(dst_prev), .sat_clear(sat_clear), .out_valid(out_valid),
    .dst_out(dst_out), .sat_sticky(sat_sticky), .undef_op(undef_op)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: loop over lanes with shifts and compares.
  task automatic model(input logic [127:0] src, input logic [1:0] code, input logic sc,
                       input logic up, input logic [127:0] prev,
                       output logic [127:0] dst, output logic sat);
    int nw = 8 << code;
    int lanes = sc ? 1 : 64 / nw;
    logic [63:0] res = '0;
    logic [63:0] maxv = (nw == 64) ? '1 : ((64'd1 << nw) - 64'd1);
    sat = 1'b0;
    for (int e = 0; e < lanes; e++) begin
      logic [127:0] t = src >> (e * 2 * nw);
      logic [63:0] el = t[63:0];
      if (nw < 32) el = el & ((64'd1 << (2 * nw)) - 64'd1);
      if (el > maxv) begin el = maxv; sat = 1'b1; end
      res = res | (el << (e * nw));
    end
    if (sc || !up) dst = {64'd0, res};
    else           dst = {res, prev[63:0]};
  endtask

  task automatic apply(input string req, input logic [127:0] src, input logic [1:0] code,
                       input logic sc, input logic up, input logic [127:0] prev, input logic clr);
    logic [127:0] d;
    logic s;
    @(negedge clk);
    src_vec = src; width_code = code; scalar_mode = sc; upper_sel = up;
    dst_prev = prev; sat_clear = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sat_clear = 1'b0;
    if (clr) exp_sat = 1'b0;
    if (code != 2'b11) begin
      model(src, code, sc, up, prev, d, s);
      exp_dst = d;
      exp_sat = exp_sat | s;
    end
    chk({req, " out_valid"}, {127'd0, out_valid}, 128'd1);
    chk({req, " undef_op"}, {127'd0, undef_op}, {127'd0, code == 2'b11});
    chk({req, " dst_out"}, dst_out, exp_dst);
    chk({req, " sat_sticky"}, {127'd0, sat_sticky}, {127'd0, exp_sat});
  endtask

  task automatic pulse_clear();
    @(negedge clk); sat_clear = 1'b1;
    @(negedge clk); sat_clear = 1'b0;
    exp_sat = 1'b0;
    chk("R8 clear only", {127'd0, sat_sticky}, 128'd0);
  endtask

  task automatic t_reset();
    chk("R10 out_valid", {127'd0, out_valid}, 128'd0);
    chk("R10 undef_op", {127'd0, undef_op}, 128'd0);
    chk("R10 sat_sticky", {127'd0, sat_sticky}, 128'd0);
    chk("R10 dst_out", dst_out, 128'd0);
  endtask

  task automatic t_vec_lower();
    // R1 R3 R4 R5: boundary 0xFF passes, 0x100 clamps
    apply("R3 b8 exact max", 128'h0000_0001_0002_0003_0004_0005_0006_00FF, 2'b00, 0, 0, '1, 0);
    apply("R1 R4 b8 mixed", 128'h0100_0042_FFFF_0000_00FF_1234_0001_0080, 2'b00, 0, 0, '1, 0);
    pulse_clear();
    apply("R1 R4 h16 mixed", 128'h0000_FFFF_0001_0000_0000_1234_FFFF_FFFF, 2'b01, 0, 0, '1, 0);
    pulse_clear();
    apply("R1 R4 w32 mixed", 128'h0000_0000_FFFF_FFFF_0000_0001_0000_0000, 2'b10, 0, 0, '1, 0);
    apply("R3 w32 pass", 128'h0000_0000_1234_5678_0000_0000_FFFF_FFFF, 2'b10, 0, 0, '0, 0);
  endtask

  task automatic t_vec_upper();
    pulse_clear();
    apply("R6 b8 upper", 128'h0055_0044_0033_0022_0011_0100_00FF_0000, 2'b00, 0, 1,
          128'hDEAD_BEEF_CAFE_F00D_0123_4567_89AB_CDEF, 0);
    apply("R6 h16 upper", 128'h0000_1111_0000_2222_0000_3333_0000_4444, 2'b01, 0, 1,
          128'h1111_2222_3333_4444_5555_6666_7777_8888, 0);
  endtask

  task automatic t_scalar();
    // R7: upper lanes huge but ignored; upper_sel has no effect
    pulse_clear();
    apply("R7 scalar b8", 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_0077, 2'b00, 1, 1, '1, 0);
    apply("R7 scalar h16", 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_0000_ABCD, 2'b01, 1, 0, '1, 0);
    apply("R7 scalar w32 clamp", 128'h0000_0000_0000_0000_0000_0001_0000_0005, 2'b10, 1, 1, '1, 0);
  endtask

  task automatic t_sticky();
    pulse_clear();
    apply("R8 set", 128'h0000_0000_0000_0000_0000_0000_0000_0100, 2'b00, 0, 0, '0, 0);
    apply("R8 hold", 128'h0, 2'b00, 0, 0, '0, 0);
    apply("R8 clear vs set", 128'h0000_0000_0000_0000_0000_0000_0000_0100, 2'b00, 0, 0, '0, 1);
    apply("R8 clear with request", 128'h0, 2'b01, 0, 0, '0, 1);
  endtask

  task automatic t_undef();
    // R2: dst and flag stay put
    apply("R2 setup", 128'h0000_0000_0000_0000_0000_0000_0000_0042, 2'b00, 0, 0, '0, 0);
    apply("R2 reserved", '1, 2'b11, 0, 1, '1, 0);
    apply("R2 reserved scalar", '1, 2'b11, 1, 0, '0, 0);
  endtask

  task automatic t_hold();
    // R9: idle cycles drop out_valid and hold dst_out
    @(negedge clk); src_vec = '1; dst_prev = '1; upper_sel = 1'b1;
    @(negedge clk);
    chk("R9 idle valid", {127'd0, out_valid}, 128'd0);
    chk("R9 idle hold", dst_out, exp_dst);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_vec_lower();
    t_vec_upper();
    t_scalar();
    t_sticky();
    t_undef();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule